// File: doc/BRIEF.md
# Front-Side Bus Cycle Master

This block sits between a processor core and a 64-bit front-side bus and turns each core request into one bus cycle. A cycle is either a single transfer of up to eight bytes, read or write, or a four-beat burst read of back-to-back 64-bit words. The core presents a request with an address, byte enables, direction, code/data and memory/IO qualifiers, and page-level caching hints. The block opens the cycle with a one-clock active-low strobe and waits for the system's active-low ready. On a read it hands each returned word back to the core. On a write it completes the cycle.

For each read, the block combines the core's own caching hints with the system's cache-enable reply, which is sampled together with ready, and reports a single cacheable verdict to the core. It also captures the system's write-back or write-through reply at that point. The strobe timing, the ready sampling window and the idle clock between cycles follow from the state sequence and cannot be configured.

Top module: `fsb_master`

## Requirements
- R1: After synchronous reset, the strobe is high (negated), the write data bus is not output-enabled, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both 1) drives `bus_strobe_n` low for exactly the next clock. In that clock the bus carries the address, `bus_be_n` = inverted `req_be`, `bus_is_data` = not `req_code`, `bus_is_write` = `req_write`, `bus_is_mem` = not `req_io`, and the page caching hints, with `bus_want_cache_n` = not `req_want_cache`.
- R3: Ready is ignored at the edge that ends the strobe clock. It is sampled at every rising edge that ends a later clock of the cycle.
- R4: A single transfer ends at the first sampled ready. `rsp_valid` and `rsp_last` are 1 for the one clock after that edge, so a cycle takes at least two clocks.
- R5: A burst request (`req_burst` = 1) runs as a read with all byte enables asserted, whatever `req_write` and `req_be` hold. It ends at the fourth sampled ready. Each beat gives one `rsp_valid` pulse, and only the fourth has `rsp_last` = 1.
- R6: On a write, `bus_oe` is 1 and `bus_dout` equals the request's write data from the clock after the strobe clock until ready is sampled. `bus_oe` is 0 at all other times.
- R7: `req_ready` is 0 from acceptance until the cycle ends. After the ready edge that ends a cycle, at least one clock passes with the strobe high before the next strobe.
- R8: On `rsp_last` of a read, `rsp_cacheable` = `req_want_cache` AND (`bus_sys_cache_n` low at the first sampled ready). A request with the page no-cache hint set and the cache wish clear is therefore never cacheable. Writes report 0.
- R9: On `rsp_last` of a read, `rsp_wback` equals `bus_sys_wback` as sampled at the first ready of that cycle.
- R10: Address, byte enable and cycle-type outputs stay constant from the strobe clock until ready is sampled.
- R11: Read data on `bus_din` is captured at the edge where ready is sampled and appears on `rsp_data` with that beat's `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_addr | input | 29 | Quadword address, byte address bits 31..3 |
| req_be | input | 8 | Byte enables, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = instruction fetch, 0 = data |
| req_io | input | 1 | 1 = IO space, 0 = memory |
| req_burst | input | 1 | 1 = four-beat burst read |
| req_pg_nocache | input | 1 | Page no-cache hint |
| req_pg_wthru | input | 1 | Page write-through hint |
| req_want_cache | input | 1 | Core wishes to cache the line |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One transfer completed |
| rsp_last | output | 1 | Final transfer of the cycle |
| rsp_data | output | 64 | Read data of the completed beat |
| rsp_cacheable | output | 1 | Resolved cacheability, valid with rsp_last |
| rsp_wback | output | 1 | System write-back reply, valid with rsp_last |
| bus_strobe_n | output | 1 | Address strobe, active low |
| bus_addr | output | 29 | Bus address bits 31..3 |
| bus_be_n | output | 8 | Byte enables, active low |
| bus_is_data | output | 1 | 1 = data, 0 = code |
| bus_is_write | output | 1 | 1 = write, 0 = read |
| bus_is_mem | output | 1 | 1 = memory, 0 = IO |
| bus_pg_nocache | output | 1 | Page no-cache hint |
| bus_pg_wthru | output | 1 | Page write-through hint |
| bus_want_cache_n | output | 1 | Cache wish, active low |
| bus_dout | output | 64 | Write data |
| bus_oe | output | 1 | Write data output enable |
| bus_din | input | 64 | Read data |
| bus_ready_n | input | 1 | Transfer ready, active low |
| bus_sys_cache_n | input | 1 | System cache enable, active low |
| bus_sys_wback | input | 1 | System reply, 1 = write-back |

## Verification
The hardest case to reach is a cycle that starts in the single idle clock right after another one ends. To get there, the stimulus raises the next request in the same half-clock in which it releases ready, so the idle gap and the strobe timing are measured at their tightest. The stimulus also drives ready low during the strobe clock to show that it is ignored. It drives cache-enable differently on the first and later burst beats, so only the first-beat sample can produce the expected cacheable verdict.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic write;
        logic code;
        logic io;
        logic burst;
        logic nocache;
        logic wthru;
        logic want_cache;
    } cyc_ctl_t;

    function automatic logic fsb_cacheable(input logic want_cache,
                                           input logic is_write,
                                           input logic sys_cache_n);
        return want_cache & ~is_write & ~sys_cache_n;
    endfunction

endpackage

// File: rtl/fsb_seq.sv
module fsb_seq
    import fsb_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       burst,
    input  logic       ready_n,
    output seq_state_e state,
    output logic       sample,
    output logic       first,
    output logic       last
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);

    logic [CW-1:0] beat_cnt;

    assign sample = (state == ST_WAIT) && !ready_n;
    assign first  = sample && (beat_cnt == '0);
    assign last   = sample && (!burst || (beat_cnt == LAST_BEAT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    beat_cnt <= '0;
                    if (accept) state <= ST_ADDR;
                end
                ST_ADDR: state <= ST_WAIT;
                ST_WAIT: begin
                    if (last) begin
                        state    <= ST_IDLE;
                        beat_cnt <= '0;
                    end else if (sample) begin
                        beat_cnt <= beat_cnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    addr_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |=> (state == ST_WAIT));

    // R5
    beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !burst) |-> (beat_cnt == '0));

endmodule

// File: rtl/fsb_cache_resolve.sv
module fsb_cache_resolve
    import fsb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic want_cache,
    input  logic is_write,
    input  logic sys_cache_n,
    input  logic sys_wback,
    output logic cacheable,
    output logic wback
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cacheable <= 1'b0;
            wback     <= 1'b0;
        end else if (first) begin
            cacheable <= fsb_cacheable(want_cache, is_write, sys_cache_n);
            wback     <= sys_wback;
        end
    end

    // R8
    no_wish_no_cache_chk: assert property (@(posedge clk) disable iff (rst)
        (first && !want_cache) |=> !cacheable);

    // R8
    write_no_cache_chk: assert property (@(posedge clk) disable iff (rst)
        (first && is_write) |=> !cacheable);

endmodule

// File: rtl/fsb_master.sv
module fsb_master
    import fsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int AW    = ADDR_W - $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_write,
    input  logic              req_code,
    input  logic              req_io,
    input  logic              req_burst,
    input  logic              req_pg_nocache,
    input  logic              req_pg_wthru,
    input  logic              req_want_cache,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_cacheable,
    output logic              rsp_wback,
    output logic              bus_strobe_n,
    output logic [AW-1:0]     bus_addr,
    output logic [BE_W-1:0]   bus_be_n,
    output logic              bus_is_data,
    output logic              bus_is_write,
    output logic              bus_is_mem,
    output logic              bus_pg_nocache,
    output logic              bus_pg_wthru,
    output logic              bus_want_cache_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready_n,
    input  logic              bus_sys_cache_n,
    input  logic              bus_sys_wback
);
    seq_state_e        state;
    logic              sample, first, last, accept;
    logic [AW-1:0]     addr_q;
    logic [BE_W-1:0]   be_q;
    cyc_ctl_t          ctl_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept = req_valid && (state == ST_IDLE);

    fsb_seq #(.BEATS(BEATS)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .burst   (ctl_q.burst),
        .ready_n (bus_ready_n),
        .state   (state),
        .sample  (sample),
        .first   (first),
        .last    (last)
    );

    fsb_cache_resolve cres_i (
        .clk         (clk),
        .rst         (rst),
        .first       (first),
        .want_cache  (ctl_q.want_cache),
        .is_write    (ctl_q.write),
        .sys_cache_n (bus_sys_cache_n),
        .sys_wback   (bus_sys_wback),
        .cacheable   (rsp_cacheable),
        .wback       (rsp_wback)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            be_q    <= '0;
            ctl_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q           <= req_addr;
            be_q             <= req_burst ? '1 : req_be;
            ctl_q.write      <= req_write & ~req_burst;
            ctl_q.code       <= req_code;
            ctl_q.io         <= req_io;
            ctl_q.burst      <= req_burst;
            ctl_q.nocache    <= req_pg_nocache;
            ctl_q.wthru      <= req_pg_wthru;
            ctl_q.want_cache <= req_want_cache;
            wdata_q          <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= sample;
            rsp_last  <= last;
            if (sample && !ctl_q.write) rsp_data <= bus_din;
        end
    end

    assign req_ready        = (state == ST_IDLE);
    assign bus_strobe_n     = (state != ST_ADDR);
    assign bus_addr         = addr_q;
    assign bus_be_n         = ~be_q;
    assign bus_is_data      = ~ctl_q.code;
    assign bus_is_write     = ctl_q.write;
    assign bus_is_mem       = ~ctl_q.io;
    assign bus_pg_nocache   = ctl_q.nocache;
    assign bus_pg_wthru     = ctl_q.wthru;
    assign bus_want_cache_n = ~ctl_q.want_cache;
    assign bus_dout         = wdata_q;
    assign bus_oe           = (state == ST_WAIT) && ctl_q.write;

    // R2
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe_n |=> bus_strobe_n);

    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> bus_strobe_n);

    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> ($stable(bus_addr) && $stable(bus_be_n) &&
                                $stable(bus_is_write) && $stable(bus_is_mem)));

    // R6
    oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (bus_is_write && bus_strobe_n));

    // R4
    rsp_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!bus_ready_n));

endmodule

// File: tb/fsb_master_tb_top.sv
`timescale 1ns/1ps
module fsb_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [28:0] req_addr = '0;
    logic [7:0]  req_be = '0;
    logic        req_write = 1'b0, req_code = 1'b0, req_io = 1'b0, req_burst = 1'b0;
    logic        req_pg_nocache = 1'b0, req_pg_wthru = 1'b0, req_want_cache = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_last, rsp_cacheable, rsp_wback;
    logic [63:0] rsp_data;
    logic        bus_strobe_n;
    logic [28:0] bus_addr;
    logic [7:0]  bus_be_n;
    logic        bus_is_data, bus_is_write, bus_is_mem, bus_pg_nocache, bus_pg_wthru;
    logic        bus_want_cache_n, bus_oe;
    logic [63:0] bus_dout;
    logic [63:0] bus_din = '0;
    logic        bus_ready_n = 1'b1, bus_sys_cache_n = 1'b1, bus_sys_wback = 1'b0;

    always #4 clk = ~clk;

    fsb_master dut_i (.*);

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 strobe, 2 waiting for ready
    int          m_phase = 0;
    int          m_beat = 0;
    logic [28:0] m_addr;
    logic [7:0]  m_be;
    logic        m_wr, m_code, m_io, m_burst, m_nc, m_wt, m_want;
    logic [63:0] m_wdata;
    logic        e_rv = 0, e_last = 0, e_cach = 0, e_wb = 0;
    logic [63:0] e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; e_rv = 0; e_last = 0; e_cach = 0; e_wb = 0; e_data = '0;
        end else begin
            e_rv = 0; e_last = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    m_addr = req_addr; m_burst = req_burst;
                    m_be = req_burst ? 8'hFF : req_be;
                    m_wr = req_write && !req_burst;
                    m_code = req_code; m_io = req_io; m_nc = req_pg_nocache;
                    m_wt = req_pg_wthru; m_want = req_want_cache; m_wdata = req_wdata;
                    m_beat = 0; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (!bus_ready_n) begin
                e_rv = 1;
                if (!m_wr) e_data = bus_din;
                if (m_beat == 0) begin
                    e_cach = m_want && !m_wr && !bus_sys_cache_n;
                    e_wb = bus_sys_wback;
                end
                m_beat++;
                if (!m_burst || m_beat == 4) begin
                    e_last = 1; m_phase = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(bus_strobe_n == (m_phase != 1), "R2", "strobe", 64'(bus_strobe_n), 64'(m_phase != 1));
            chk(req_ready == (m_phase == 0), "R7", "req_ready", 64'(req_ready), 64'(m_phase == 0));
            chk(bus_oe == (m_phase == 2 && m_wr), "R6", "oe", 64'(bus_oe), 64'(m_phase == 2 && m_wr));
            if (m_phase != 0) begin
                chk(bus_addr == m_addr, "R10", "addr", 64'(bus_addr), 64'(m_addr));
                chk(bus_be_n == ~m_be, "R5", "be_n", 64'(bus_be_n), 64'(~m_be));
                chk({bus_is_data, bus_is_write, bus_is_mem} == {!m_code, m_wr, !m_io},
                    "R2", "type", 64'({bus_is_data, bus_is_write, bus_is_mem}), 64'({!m_code, m_wr, !m_io}));
                chk({bus_pg_nocache, bus_pg_wthru, bus_want_cache_n} == {m_nc, m_wt, !m_want},
                    "R2", "hints", 64'({bus_pg_nocache, bus_pg_wthru, bus_want_cache_n}), 64'({m_nc, m_wt, !m_want}));
            end
            if (m_phase == 2 && m_wr)
                chk(bus_dout == m_wdata, "R6", "dout", bus_dout, m_wdata);
            chk(rsp_valid == e_rv, "R4", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
            chk(rsp_last == e_last, "R5", "rsp_last", 64'(rsp_last), 64'(e_last));
            if (e_rv && !m_wr)
                chk(rsp_data == e_data, "R11", "rsp_data", rsp_data, e_data);
            if (e_last) begin
                chk(rsp_cacheable == e_cach, "R8", "cacheable", 64'(rsp_cacheable), 64'(e_cach));
                chk(rsp_wback == e_wb, "R9", "wback", 64'(rsp_wback), 64'(e_wb));
            end
        end
    end

    task automatic start_req(input logic [28:0] a, input logic [7:0] be, input bit wr,
                             input bit code, input bit io, input bit burst, input bit nc,
                             input bit wt, input bit want, input logic [63:0] wd,
                             input bit skip_wait, input bit early_rdy);
        if (!skip_wait) @(negedge clk);
        req_addr = a; req_be = be; req_write = wr; req_code = code; req_io = io;
        req_burst = burst; req_pg_nocache = nc; req_pg_wthru = wt; req_want_cache = want;
        req_wdata = wd; req_valid = 1'b1; bus_ready_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (early_rdy) begin
            bus_ready_n = 1'b0;
            bus_sys_cache_n = 1'b0;
        end
    endtask

    // Each beat: dly clocks without ready, then one clock with ready low.
    task automatic serve(input int nb, input int dly, input bit first_ken_n,
                         input bit later_ken_n, input bit wb, input logic [63:0] dbase);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            bus_ready_n = 1'b1;
            repeat (dly) @(negedge clk);
            bus_ready_n = 1'b0;
            bus_din = dbase + 64'(b) * 64'h1111;
            bus_sys_cache_n = (b == 0) ? first_ken_n : later_ken_n;
            bus_sys_wback = (b == 0) ? wb : ~wb;
        end
        @(negedge clk);
        bus_ready_n = 1'b1;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL R4 watchdog act=hang exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_strobe_n === 1'b1, "R1", "strobe", 64'(bus_strobe_n), 64'd1);
        chk(bus_oe === 1'b0, "R1", "oe", 64'(bus_oe), 64'd0);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(req_ready === 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);

        // single cacheable read, fastest ready
        start_req(29'h0ABCDEF, 8'h0F, 0, 0, 0, 0, 0, 0, 1, '0, 0, 0);
        serve(1, 0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0);

        // R3: ready low during the strobe clock must be ignored
        start_req(29'h0000123, 8'h03, 0, 1, 0, 0, 0, 1, 1, '0, 0, 1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R3", "early ready ignored", 64'(rsp_valid), 64'd0);
        bus_ready_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_ready_n = 1'b0; bus_din = 64'hCAFE; bus_sys_cache_n = 1'b1; bus_sys_wback = 1'b0;
        @(negedge clk);
        bus_ready_n = 1'b1;

        // single write with wait states, then read in the minimum idle gap (R7)
        start_req(29'h1FFFFFF, 8'hF0, 1, 0, 1, 0, 1, 0, 0, 64'hDEAD_BEEF_0000_5555, 0, 0);
        serve(1, 2, 1, 1, 0, '0);
        start_req(29'h0000040, 8'hFF, 0, 0, 0, 0, 0, 0, 1, '0, 1, 0);
        serve(1, 1, 0, 0, 0, 64'h7777);

        // R5 burst read: cache enable only on first beat
        start_req(29'h0000100, 8'h01, 0, 0, 0, 1, 0, 0, 1, '0, 0, 0);
        serve(4, 1, 0, 1, 1, 64'hA000);
        // burst with write set runs as a read; later beats enable cache, first not
        start_req(29'h0000200, 8'h10, 1, 0, 0, 1, 0, 1, 1, 64'h99, 1, 0);
        serve(4, 0, 1, 0, 0, 64'hB000);

        // R8: page no-cache with cache wish clear, system says cacheable
        start_req(29'h0000300, 8'hFF, 0, 0, 0, 0, 1, 0, 0, '0, 0, 0);
        serve(1, 0, 0, 0, 1, 64'h5A5A);
        // R9: write-through reply on a cacheable read
        start_req(29'h0000308, 8'hFF, 0, 0, 0, 0, 0, 1, 1, '0, 0, 0);
        serve(1, 3, 0, 0, 0, 64'h3C3C);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule